// File: doc/BRIEF.md
# Double-Buffered PWM Timing Register Loader

This block keeps a second, software-facing copy of every PWM timing value: one duty compare value per channel and the clock prescaler select. Software writes go only to these shadow copies. The live values that the PWM counter and comparators use are held in a separate set of active registers. They change only as one group, so the output never shows a pulse width or period built from a mix of old and new settings.

A group transfer needs two things. First, software arms it by setting a ready flag. Second, a reload event must occur. A period divider counts the end-of-period pulses from the PWM counter and raises a reload event once every 1, 2, 4 or 8 periods, as the two-bit ratio field selects. Every reload event is also given out as a one-cycle strobe. Other logic, such as output polarity switching, can align to it whether or not a transfer took place.

Writes use a flat address map:
- Addresses 0 to NUM_CH-1 hold the duty shadows.
- Address NUM_CH holds the prescaler shadow.
- Address NUM_CH+1 is the control word. Bit 0 arms the transfer, and bits 2:1 give the ratio select.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: After reset, all active duty values, the active prescaler, ready_o and reload_o are 0. The ratio select is 0, which means one reload event per period.
- R2: A write to address c (with c < NUM_CH) loads wr_data_i[DUTY_W-1:0] into the duty shadow of channel c. A write to address NUM_CH loads wr_data_i[PRESC_W-1:0] into the prescaler shadow. Neither write changes duty_act_o or presc_act_o.
- R3: With ratio select s, a reload event occurs on every 2^s-th period_end_i pulse, counting from reset or from the last control write. reload_o is high for exactly the one cycle after the pulse that completes the group.
- R4: A write to address NUM_CH+1 loads the ratio select from wr_data_i[2:1] and restarts the period count from zero.
- R5: A control write with wr_data_i[0]=1 sets the ready flag. ready_o then reads 1 until the transfer happens. A control write with bit 0 at 0 leaves the flag as it is.
- R6: When a reload event occurs with the ready flag at 1, all duty values and the prescaler move from the shadows to the active outputs on the same edge that raises reload_o. The ready flag clears on that same edge.
- R7: A reload event with the ready flag at 0 still pulses reload_o, and it leaves all active outputs unchanged.
- R8: Shadow writes made while a transfer is pending are accepted. The last value written before the reload event is the one that is transferred.
- R9: If a shadow write and an armed reload event fall in the same cycle, the transfer uses the value the shadow held before that write. The new value stays in the shadow for the next armed transfer.
- R10: If the ready flag is set in the same cycle as a reload event while it was 0, no transfer happens at that event. The flag stays 1, and the transfer happens at the following event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DUTY_W | Write data |
| period_end_i | input | 1 | One-cycle pulse at the end of each PWM period |
| duty_act_o | output | NUM_CH*DUTY_W | Active duty values, with channel 0 in the low bits |
| presc_act_o | output | PRESC_W | Active prescaler select |
| ready_o | output | 1 | Transfer armed and pending |
| reload_o | output | 1 | One-cycle reload event strobe |

## Verification
Register writes and the reload event can land on the same clock edge. This is where the block is most likely to go wrong. The bench provokes the overlap by asserting period_end_i in the very cycle that writes a duty shadow, and in the very cycle that arms the ready flag. It then judges the result against a requirement-level model that applies the transfer with the pre-write shadow values. It also checks that the armed value only appears at the next event, and that the flag is still 1 in between.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;

    typedef enum logic [1:0] {
        RATIO_1 = 2'd0,
        RATIO_2 = 2'd1,
        RATIO_4 = 2'd2,
        RATIO_8 = 2'd3
    } ratio_e;

    localparam int PCNT_W = 3;

    typedef struct packed {
        ratio_e             sel;
        logic [PCNT_W-1:0]  cnt;
    } div_st_t;

    typedef struct packed {
        logic ready;
        logic reload;
    } ctl_st_t;

    function automatic logic [PCNT_W-1:0] last_index(input ratio_e sel);
        logic [PCNT_W:0] len;
        len = (PCNT_W+1)'(1) << sel;
        return PCNT_W'(len - 1'b1);
    endfunction

endpackage

// File: rtl/pwm_period_div.sv
module pwm_period_div
    import pwm_reload_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       period_end_i,
    input  logic       ratio_wr_i,
    input  logic [1:0] ratio_i,
    output logic       event_o
);

    div_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        event_o = period_end_i && (st_q.cnt == last_index(st_q.sel));
        if (ratio_wr_i) begin
            st_d.sel = ratio_e'(ratio_i);
            st_d.cnt = '0;
        end else if (period_end_i) begin
            st_d.cnt = event_o ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{sel: RATIO_1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // count never passes the last index of the selected group
    assert_cnt_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= last_index(st_q.sel));

    // a ratio write restarts the count
    assert_restart_on_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ratio_wr_i |=> (st_q.cnt == '0));

endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank #(
    parameter int NUM_CH  = 3,
    parameter int DUTY_W  = 12,
    parameter int PRESC_W = 3
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_CH-1:0]        duty_we_i,
    input  logic                     presc_we_i,
    input  logic [DUTY_W-1:0]        wr_data_i,
    input  logic                     load_i,
    output logic [NUM_CH*DUTY_W-1:0] duty_act_o,
    output logic [PRESC_W-1:0]       presc_act_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][DUTY_W-1:0] duty_sh;
        logic [NUM_CH-1:0][DUTY_W-1:0] duty_act;
        logic [PRESC_W-1:0]            presc_sh;
        logic [PRESC_W-1:0]            presc_act;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        // transfer takes the shadows as they stood before this cycle's writes
        if (load_i) begin
            bank_d.duty_act  = bank_q.duty_sh;
            bank_d.presc_act = bank_q.presc_sh;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (duty_we_i[c]) begin
                bank_d.duty_sh[c] = wr_data_i;
            end
        end
        if (presc_we_i) begin
            bank_d.presc_sh = wr_data_i[PRESC_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_out
            assign duty_act_o[g*DUTY_W +: DUTY_W] = bank_q.duty_act[g];
        end
    endgenerate
    assign presc_act_o = bank_q.presc_act;

    // active values only move on a transfer
    assert_act_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> ($stable(duty_act_o) && $stable(presc_act_o)));

endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
    import pwm_reload_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int DUTY_W  = 12,
    parameter int PRESC_W = 3,
    parameter int ADDR_W  = 3
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [DUTY_W-1:0]        wr_data_i,
    input  logic                     period_end_i,
    output logic [NUM_CH*DUTY_W-1:0] duty_act_o,
    output logic [PRESC_W-1:0]       presc_act_o,
    output logic                     ready_o,
    output logic                     reload_o
);

    localparam int ADDR_PRESC = NUM_CH;
    localparam int ADDR_CTRL  = NUM_CH + 1;

    logic [NUM_CH-1:0] duty_we;
    logic              presc_we;
    logic              ctrl_we;
    logic              arm_set;
    logic              reload_ev;
    logic              xfer;

    ctl_st_t ctl_d, ctl_q;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_dec
            assign duty_we[g] = wr_en_i && (wr_addr_i == ADDR_W'(g));
        end
    endgenerate

    assign presc_we = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_PRESC));
    assign ctrl_we  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));
    assign arm_set  = ctrl_we && wr_data_i[0];

    pwm_period_div u_div (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .period_end_i (period_end_i),
        .ratio_wr_i   (ctrl_we),
        .ratio_i      (wr_data_i[2:1]),
        .event_o      (reload_ev)
    );

    always_comb begin
        ctl_d        = ctl_q;
        xfer         = reload_ev && ctl_q.ready;
        ctl_d.reload = reload_ev;
        if (arm_set) begin
            ctl_d.ready = 1'b1;
        end else if (xfer) begin
            ctl_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pwm_shadow_bank #(
        .NUM_CH  (NUM_CH),
        .DUTY_W  (DUTY_W),
        .PRESC_W (PRESC_W)
    ) u_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .duty_we_i   (duty_we),
        .presc_we_i  (presc_we),
        .wr_data_i   (wr_data_i),
        .load_i      (xfer),
        .duty_act_o  (duty_act_o),
        .presc_act_o (presc_act_o)
    );

    assign ready_o  = ctl_q.ready;
    assign reload_o = ctl_q.reload;

    // every divider event shows up as a strobe one cycle later
    assert_strobe_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reload_ev |=> reload_o);

    // armed event without a fresh arm clears the flag
    assert_ready_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reload_ev && ready_o && !arm_set) |=> !ready_o);

    // flag only rises after an arming control write
    assert_ready_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ready_o && !arm_set) |=> !ready_o);

endmodule

// File: tb/pwm_reload_ctrl_bench.sv
module pwm_reload_ctrl_bench;

    localparam int CLK_P = 10;
    localparam int NCH   = 3;
    localparam int DW    = 12;
    localparam int PW    = 3;

    typedef struct {
        logic [NCH*DW-1:0] duty;
        logic [PW-1:0]     presc;
        logic              rdy;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [DW-1:0]     wr_data = '0;
    logic              period_end = 1'b0;
    logic [NCH*DW-1:0] duty_act;
    logic [PW-1:0]     presc_act;
    logic              ready;
    logic              reload;

    int n_chk = 0;
    int n_bad = 0;

    exp_t q[$];

    logic [DW-1:0] m_sh [NCH];
    logic [DW-1:0] m_act[NCH];
    logic [PW-1:0] m_psh, m_pact;
    logic          m_rdy;
    int            m_cnt, m_sel;

    always #(CLK_P/2) clk = ~clk;

    pwm_reload_ctrl u_pwm_reload_ctrl (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .period_end_i (period_end),
        .duty_act_o   (duty_act),
        .presc_act_o  (presc_act),
        .ready_o      (ready),
        .reload_o     (reload)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NCH*DW-1:0] m_flat();
        logic [NCH*DW-1:0] v;
        for (int c = 0; c < NCH; c++) v[c*DW +: DW] = m_act[c];
        return v;
    endfunction

    // driver: applies one cycle of stimulus, advances the model, queues expected transfers
    task automatic step(input logic pe, input logic we, input logic [2:0] a,
                        input logic [DW-1:0] d, input string tag);
        logic ev;
        exp_t it;
        period_end = pe; wr_en = we; wr_addr = a; wr_data = d;
        ev = pe && (m_cnt == ((1 << m_sel) - 1));
        if (ev && m_rdy) begin
            for (int c = 0; c < NCH; c++) m_act[c] = m_sh[c];
            m_pact = m_psh;
            m_rdy  = 1'b0;
        end
        if (we) begin
            if (a < NCH) m_sh[a] = d;
            else if (a == NCH) m_psh = d[PW-1:0];
            else if (a == NCH + 1) begin
                if (d[0]) m_rdy = 1'b1;
                m_sel = int'(d[2:1]);
                m_cnt = 0;
            end
        end
        if (!(we && a == NCH + 1) && pe) m_cnt = ev ? 0 : m_cnt + 1;
        if (ev) begin
            it.duty = m_flat(); it.presc = m_pact; it.rdy = m_rdy;
            q.push_back(it);
        end
        @(negedge clk);
        period_end = 1'b0; wr_en = 1'b0;
        chk(reload == ev, tag, reload, ev);
    endtask

    task automatic check_state(input string tag);
        chk(duty_act == m_flat(), {tag, " duty"}, duty_act, m_flat());
        chk(presc_act == m_pact, {tag, " presc"}, presc_act, m_pact);
        chk(ready == m_rdy, {tag, " ready"}, ready, m_rdy);
    endtask

    // monitor: pops the expected transfer on every strobe
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            if (rst_n && reload) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R3 unexpected strobe", 1, 0);
                end else begin
                    it = q.pop_front();
                    chk(duty_act == it.duty, "R6 duty on strobe", duty_act, it.duty);
                    chk(presc_act == it.presc, "R6 presc on strobe", presc_act, it.presc);
                    chk(ready == it.rdy, "R6 ready on strobe", ready, it.rdy);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin m_sh[c] = '0; m_act[c] = '0; end
        m_psh = '0; m_pact = '0; m_rdy = 1'b0; m_cnt = 0; m_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_state("R1 reset");
        chk(reload == 1'b0, "R1 strobe", reload, 0);

        // R2 shadow writes leave active values alone
        step(0, 1, 3'd0, 12'h123, "R2");
        step(0, 1, 3'd1, 12'h456, "R2");
        step(0, 1, 3'd2, 12'h789, "R2");
        step(0, 1, 3'd3, 12'h005, "R2");
        check_state("R2 after writes");

        // R7 unarmed events: strobe but no change
        step(1, 0, 0, 0, "R7 strobe");
        step(1, 0, 0, 0, "R7 strobe");
        check_state("R7 hold");

        // R5 arm, R6 transfer
        step(0, 1, 3'd4, 12'h001, "R5");
        check_state("R5 armed");
        step(0, 0, 0, 0, "R5");
        check_state("R5 still pending");
        step(1, 0, 0, 0, "R6 armed event");
        check_state("R6 after transfer");

        // R3 ratio 4: events on every 4th pulse
        step(0, 1, 3'd4, 12'h004, "R3");
        for (int i = 0; i < 9; i++) step(1, 0, 0, 0, "R3 ratio4");

        // R8 ratio 8, overwrite while pending
        step(0, 1, 3'd4, 12'h007, "R8 arm");
        step(0, 1, 3'd0, 12'hAAA, "R8");
        step(1, 1, 3'd0, 12'hBBB, "R8");
        step(0, 1, 3'd3, 12'h002, "R8");
        for (int i = 0; i < 7; i++) step(1, 0, 0, 0, "R8 ratio8");
        check_state("R8 last value");

        // R9 shadow write in the armed event cycle
        step(0, 1, 3'd4, 12'h001, "R9 arm");
        step(0, 1, 3'd1, 12'h111, "R9");
        step(1, 1, 3'd1, 12'h222, "R9 collide");
        check_state("R9 old value");
        step(0, 1, 3'd4, 12'h001, "R9 rearm");
        step(1, 0, 0, 0, "R9 next");
        check_state("R9 new value");

        // R10 arm in the event cycle
        step(0, 1, 3'd2, 12'h333, "R10");
        step(1, 1, 3'd4, 12'h001, "R10 collide");
        check_state("R10 no transfer");
        step(1, 0, 0, 0, "R10 next");
        check_state("R10 transfer");

        // R4 restart of the count
        step(0, 1, 3'd4, 12'h002, "R4");
        step(1, 0, 0, 0, "R4 first");
        step(0, 1, 3'd4, 12'h002, "R4 restart");
        step(1, 0, 0, 0, "R4 after restart");
        step(1, 0, 0, 0, "R4 event");
        check_state("R4 final");

        repeat (2) @(negedge clk);
        chk(q.size() == 0, "R3 missing strobes", q.size(), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule